// File: doc/BRIEF.md
# Request-Paced DMA Write Controller

This block governs the write half of a memory-to-memory copy channel. Software programs a word count, source and destination start addresses, a per-request block size and a pacing enable, then pulses a start strobe. The read half then fetches source words into an eight-entry buffer, up to the buffer's capacity. It needs no permission from anyone to do so. The write half drains that buffer to incrementing destination addresses. When pacing is enabled, an external device must raise its request line before each block of writes. Each accepted request releases exactly one block, and the block cannot be halted part-way except by the destination deasserting its ready input.

The request line is asynchronous, so it is synchronised and only its rising edges count. An edge that arrives while a block is still running is queued in a small saturating counter and served later. A word counter falls by one on every destination write. When it reaches zero, the channel stops, raises done and discards any queued requests. With pacing disabled, the writes run freely whenever buffered data is present.

The control core is a five-state machine. ST_IDLE (after reset) and ST_DONE both leave on start: to ST_DONE if the word count is zero, to ST_WAIT if pacing is on, and to ST_FREE otherwise. ST_FREE moves to ST_DONE on the final write, or to ST_WAIT when pacing is switched on. ST_WAIT moves to ST_FREE when pacing is switched off, or to ST_BURST when a queued request exists. ST_BURST moves to ST_DONE on the final word, or back to ST_WAIT when its last block word is written. A start pulse in any state restarts the channel.

Top module: `hs_wr_pacer`

## Requirements
- R1: With `cfg_en` low, destination writes occur on every cycle that has buffered data and `dst_ready` high, until the word count is used up, with no request needed.
- R2: With `cfg_en` high, no write is presented outside a granted block, and each accepted request grants exactly `cfg_blk_init` writes. The last block is shortened if the remaining word count is smaller.
- R3: A `cfg_blk_init` value of 0 grants one write per request, the same as a value of 1.
- R4: Once a block has begun, it completes with no further request. While `dst_ready` is low, `dst_we`, `dst_addr` and `dst_data` hold steady.
- R5: Request edges seen while a block is open or while waiting are queued in `stat_pend`, which saturates at 2^PW-1. The queued edges are served one block each, with no loss.
- R6: After start, the read side issues `src_cmd` pulses until buffered plus outstanding words reach 8, whether or not requests arrive. It issues further pulses only as slots free, up to the word count.
- R7: The k-th write (from 0) goes to `cfg_dst_base`+k and carries the data returned for the k-th read, which was issued at `src_addr` = `cfg_src_base`+k. The destination address steps by one per accepted write.
- R8: When the programmed number of words has been written, `stat_done` goes high, `stat_pend` clears to 0, and no further writes are presented.
- R9: `stat_busy` is high exactly while writes are permitted (a block is open, or pacing is off and the channel is running). It is low while waiting for a request.
- R10: After reset, `dst_we`, `src_cmd`, `stat_busy`, `stat_done` and `stat_pend` are all 0.
- R11: A request held high for many cycles counts as a single request, which releases one block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Pacing enable (1 = writes wait for requests) |
| cfg_blk_init | input | BW | Writes per accepted request (0 behaves as 1) |
| cfg_total | input | CW | Total words to transfer, loaded on start |
| cfg_src_base | input | AW | First source address |
| cfg_dst_base | input | AW | First destination address |
| cfg_start | input | 1 | One-cycle pulse that (re)starts the channel |
| stat_busy | output | 1 | Writes currently permitted |
| stat_done | output | 1 | Transfer complete |
| stat_pend | output | PW | Queued request count |
| req_in | input | 1 | Asynchronous request from the external device |
| src_cmd | output | 1 | Read command issued this cycle |
| src_addr | output | AW | Address of the read command |
| src_rvalid | input | 1 | Read data returning |
| src_rdata | input | DW | Returned read data |
| dst_we | output | 1 | Write presented |
| dst_addr | output | AW | Write address |
| dst_data | output | DW | Write data |
| dst_ready | input | 1 | Destination accepts the write this cycle |

## Verification
The hardest case to reach is a request queue that is non-empty while a block is open. A block normally drains within a few cycles, long before the synchroniser has passed the next edge through. The stimulus therefore holds `dst_ready` low so that a granted block stays frozen in ST_BURST. It then pulses the request line twice more and reads the queued count. Finally it releases ready and confirms that every queued block is written. The same freeze, with a word count equal to a single block, shows that the completion cycle discards the queue.

// File: rtl/hs_pacer_pkg.sv
package hs_pacer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FREE  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_BURST = 3'd3,
        ST_DONE  = 3'd4
    } pacer_state_e;

endpackage

// File: rtl/hs_req_sync.sv
module hs_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], req_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign req_rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/hs_prefetch_buf.sv
module hs_prefetch_buf #(
    parameter int DW    = 16,
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [CW-1:0] total,
    input  logic          src_rvalid,
    input  logic [DW-1:0] src_rdata,
    input  logic          pop,
    output logic          src_cmd,
    output logic [AW-1:0] src_addr,
    output logic          head_valid,
    output logic [DW-1:0] head_data,
    output logic [LW-1:0] fill_level,
    output logic [LW-1:0] in_flight
);

    logic [DW-1:0]   mem [DEPTH];
    logic [PTRW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0]   rd_left;
    logic [LW:0]     slots_used;

    assign slots_used = {1'b0, fill_level} + {1'b0, in_flight};
    assign src_cmd    = !start && (rd_left != '0) && (slots_used < (LW+1)'(DEPTH));
    assign head_valid = (fill_level != '0);
    assign head_data  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (src_rvalid) mem[wr_ptr] <= src_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            fill_level <= '0;
            in_flight  <= '0;
            rd_left    <= '0;
            src_addr   <= '0;
        end else if (start) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            fill_level <= '0;
            in_flight  <= '0;
            rd_left    <= total;
            src_addr   <= src_base;
        end else begin
            if (src_rvalid) wr_ptr <= wr_ptr + 1'b1;
            if (pop)        rd_ptr <= rd_ptr + 1'b1;
            fill_level <= fill_level + LW'(src_rvalid) - LW'(pop);
            in_flight  <= in_flight + LW'(src_cmd) - LW'(src_rvalid);
            if (src_cmd) begin
                rd_left  <= rd_left - 1'b1;
                src_addr <= src_addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hs_pacer_fsm.sv
module hs_pacer_fsm
    import hs_pacer_pkg::*;
#(
    parameter int CW = 16,
    parameter int BW = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          en,
    input  logic [CW-1:0] total,
    input  logic [BW-1:0] blk_init,
    input  logic          req_rise,
    input  logic          head_valid,
    input  logic          dst_ready,
    output pacer_state_e  state_q,
    output logic          dst_we,
    output logic          fire,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] pend_cnt
);

    localparam logic [PW-1:0] PEND_MAX = '1;

    pacer_state_e  nxt;
    logic [BW-1:0] blk_left;
    logic [CW-1:0] words_left;
    logic          accept, counting, inc, last_word, last_blk;

    assign last_word = (words_left == CW'(1));
    assign last_blk  = (blk_left == BW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    always_comb begin
        nxt = state_q;
        if (start) begin
            if (total == '0) nxt = ST_DONE;
            else if (en)     nxt = ST_WAIT;
            else             nxt = ST_FREE;
        end else begin
            unique case (state_q)
                ST_IDLE:  nxt = ST_IDLE;
                ST_FREE: begin
                    if (fire && last_word) nxt = ST_DONE;
                    else if (en)           nxt = ST_WAIT;
                end
                ST_WAIT: begin
                    if (!en)                 nxt = ST_FREE;
                    else if (pend_cnt != '0) nxt = ST_BURST;
                end
                ST_BURST: begin
                    if (fire && last_word)     nxt = ST_DONE;
                    else if (fire && last_blk) nxt = ST_WAIT;
                end
                ST_DONE:  nxt = ST_DONE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state_q == ST_BURST) || (state_q == ST_FREE);
        done     = (state_q == ST_DONE);
        dst_we   = busy && head_valid;
        fire     = dst_we && dst_ready;
        accept   = (state_q == ST_WAIT) && en && (pend_cnt != '0) && !start;
        counting = (state_q == ST_FREE) || (state_q == ST_WAIT) || (state_q == ST_BURST);
        inc      = req_rise && counting && ((pend_cnt != PEND_MAX) || accept);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_left   <= '0;
            words_left <= '0;
            pend_cnt   <= '0;
        end else begin
            if (start)       words_left <= total;
            else if (fire)   words_left <= words_left - 1'b1;

            if (accept)      blk_left <= (blk_init == '0) ? BW'(1) : blk_init;
            else if (fire && state_q == ST_BURST) blk_left <= blk_left - 1'b1;

            if (start || nxt == ST_DONE) pend_cnt <= '0;
            else pend_cnt <= pend_cnt + PW'(inc) - PW'(accept);
        end
    end

endmodule

// File: rtl/hs_wr_pacer.sv
module hs_wr_pacer
    import hs_pacer_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int CW          = 16,
    parameter int BW          = 16,
    parameter int PW          = 4,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [BW-1:0] cfg_blk_init,
    input  logic [CW-1:0] cfg_total,
    input  logic [AW-1:0] cfg_src_base,
    input  logic [AW-1:0] cfg_dst_base,
    input  logic          cfg_start,
    output logic          stat_busy,
    output logic          stat_done,
    output logic [PW-1:0] stat_pend,
    input  logic          req_in,
    output logic          src_cmd,
    output logic [AW-1:0] src_addr,
    input  logic          src_rvalid,
    input  logic [DW-1:0] src_rdata,
    output logic          dst_we,
    output logic [AW-1:0] dst_addr,
    output logic [DW-1:0] dst_data,
    input  logic          dst_ready
);

    localparam int LW = $clog2(DEPTH + 1);

    pacer_state_e  fsm_state;
    logic          req_rise, fire, head_valid;
    logic [DW-1:0] head_data;
    logic [LW-1:0] fill_level, in_flight;

    hs_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (req_in),
        .req_rise  (req_rise)
    );

    hs_prefetch_buf #(.DW(DW), .AW(AW), .CW(CW), .DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cfg_start),
        .src_base   (cfg_src_base),
        .total      (cfg_total),
        .src_rvalid (src_rvalid),
        .src_rdata  (src_rdata),
        .pop        (fire),
        .src_cmd    (src_cmd),
        .src_addr   (src_addr),
        .head_valid (head_valid),
        .head_data  (head_data),
        .fill_level (fill_level),
        .in_flight  (in_flight)
    );

    hs_pacer_fsm #(.CW(CW), .BW(BW), .PW(PW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cfg_start),
        .en         (cfg_en),
        .total      (cfg_total),
        .blk_init   (cfg_blk_init),
        .req_rise   (req_rise),
        .head_valid (head_valid),
        .dst_ready  (dst_ready),
        .state_q    (fsm_state),
        .dst_we     (dst_we),
        .fire       (fire),
        .busy       (stat_busy),
        .done       (stat_done),
        .pend_cnt   (stat_pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         dst_addr <= '0;
        else if (cfg_start) dst_addr <= cfg_dst_base;
        else if (fire)      dst_addr <= dst_addr + 1'b1;
    end

    assign dst_data = head_data;

endmodule

// File: rtl/hs_wr_pacer_chk.sv
module hs_wr_pacer_chk
    import hs_pacer_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int PW    = 4,
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input pacer_state_e  state,
    input logic          dst_we,
    input logic          dst_ready,
    input logic [AW-1:0] dst_addr,
    input logic [DW-1:0] dst_data,
    input logic          busy,
    input logic          done,
    input logic [PW-1:0] pend_cnt,
    input logic [LW-1:0] fill_level,
    input logic [LW-1:0] in_flight
);

    AST_WAIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !dst_we); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && dst_we && !dst_ready && !start)
        |=> (dst_we && $stable(dst_addr) && $stable(dst_data))); // R4

    AST_PREFETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(fill_level) + 32'(in_flight)) <= DEPTH); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && dst_ready && !start) |=> (dst_addr == $past(dst_addr) + 1'b1)); // R7

    AST_DONE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pend_cnt == '0)); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (!dst_we && !busy)); // R8

endmodule

bind hs_wr_pacer hs_wr_pacer_chk #(
    .AW(AW), .DW(DW), .PW(PW), .DEPTH(DEPTH), .LW(LW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cfg_start),
    .state      (fsm_state),
    .dst_we     (dst_we),
    .dst_ready  (dst_ready),
    .dst_addr   (dst_addr),
    .dst_data   (dst_data),
    .busy       (stat_busy),
    .done       (stat_done),
    .pend_cnt   (stat_pend),
    .fill_level (fill_level),
    .in_flight  (in_flight)
);

// File: tb/sim_hs_wr_pacer.sv
module sim_hs_wr_pacer;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SRC_BASE = 16'h0200;
    localparam logic [15:0] DST_BASE = 16'h8000;
    localparam logic [15:0] PATTERN  = 16'hA5A5;

    typedef struct packed {
        logic        en;
        logic [15:0] blk;
        logic [15:0] tot;
        logic [7:0]  nreq;
        logic [15:0] expw;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'd4, 16'd20, 8'd1, 16'd4, 2'd0},
        '{1'b1, 16'd1, 16'd10, 8'd3, 16'd3, 2'd1},
        '{1'b1, 16'd0, 16'd10, 8'd2, 16'd2, 2'd0},
        '{1'b1, 16'd5, 16'd7,  8'd2, 16'd7, 2'd1},
        '{1'b0, 16'd3, 16'd9,  8'd0, 16'd9, 2'd1},
        '{1'b1, 16'd3, 16'd9,  8'd3, 16'd9, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [15:0] cfg_blk_init = '0;
    logic [15:0] cfg_total = '0;
    logic        cfg_start = 1'b0;
    logic        req_in = 1'b0;
    logic        src_rvalid = 1'b0;
    logic [15:0] src_rdata = '0;
    logic        dst_ready = 1'b1;
    logic        stat_busy, stat_done, src_cmd, dst_we;
    logic [3:0]  stat_pend;
    logic [15:0] src_addr, dst_addr, dst_data;

    int errs = 0, checks = 0, cyc = 0;
    int wr_k = 0, cmd_k = 0, data_err = 0;
    int stall_mode = 0;
    logic        pv = 1'b0;
    logic [15:0] pd = '0;
    bit          finished = 0;

    hs_wr_pacer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_blk_init(cfg_blk_init),
        .cfg_total(cfg_total), .cfg_src_base(SRC_BASE), .cfg_dst_base(DST_BASE),
        .cfg_start(cfg_start), .stat_busy(stat_busy), .stat_done(stat_done),
        .stat_pend(stat_pend), .req_in(req_in), .src_cmd(src_cmd), .src_addr(src_addr),
        .src_rvalid(src_rvalid), .src_rdata(src_rdata), .dst_we(dst_we),
        .dst_addr(dst_addr), .dst_data(dst_data), .dst_ready(dst_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Source memory model (one-cycle latency) and destination monitor.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            src_rvalid = 1'b0; pv = 1'b0; dst_ready = 1'b1;
        end else begin
            if (cfg_start) begin
                wr_k = 0; cmd_k = 0; pv = 1'b0;
            end
            src_rvalid = pv;
            src_rdata  = pd;
            pv = src_cmd;
            pd = src_addr ^ PATTERN;
            if (src_cmd) begin
                if (src_addr != SRC_BASE + 16'(cmd_k)) data_err++;
                cmd_k++;
            end
            case (stall_mode)
                0:       dst_ready = 1'b1;
                1:       dst_ready = (cyc % 3) != 0;
                default: dst_ready = 1'b0;
            endcase
            if (dst_we && dst_ready) begin
                if (dst_addr != DST_BASE + 16'(wr_k) ||
                    dst_data != ((SRC_BASE + 16'(wr_k)) ^ PATTERN)) data_err++;
                wr_k++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start_chan(input logic en, input int blk, input int tot);
        cfg_en = en; cfg_blk_init = 16'(blk); cfg_total = 16'(tot);
        cfg_start = 1'b1;
        step(1);
        cfg_start = 1'b0;
    endtask

    task automatic pulse_req(input int high_cycles);
        req_in = 1'b1;
        step(high_cycles);
        req_in = 1'b0;
        step(4);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        step(3);
        // R10: reset state
        chk("R10 dst_we", int'(dst_we), 0);
        chk("R10 src_cmd", int'(src_cmd), 0);
        chk("R10 busy", int'(stat_busy), 0);
        chk("R10 done", int'(stat_done), 0);
        chk("R10 pend", int'(stat_pend), 0);
        rst_n = 1'b1;
        step(2);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = (v == 4) ? "R1" : (v == 2) ? "R3" : "R2";
            stall_mode = int'(VECS[v].stall);
            start_chan(VECS[v].en, int'(VECS[v].blk), int'(VECS[v].tot));
            for (int r = 0; r < int'(VECS[v].nreq); r++) pulse_req(3);
            step(80);
            chk({tag, " writes"}, wr_k, int'(VECS[v].expw));
            chk("R7 data order", data_err, 0);
            chk("R8 done", int'(stat_done), int'(VECS[v].expw == VECS[v].tot));
        end

        // R6: prefetch fills 8 slots with no request
        stall_mode = 0;
        start_chan(1'b1, 8, 40);
        step(20);
        chk("R6 prefetch", cmd_k, 8);
        chk("R2 no write", wr_k, 0);
        chk("R9 idle", int'(stat_busy), 0);

        // R4/R5: block frozen by ready, requests queued
        stall_mode = 2;
        pulse_req(3);
        step(4);
        chk("R9 busy", int'(stat_busy), 1);
        chk("R4 stalled", wr_k, 0);
        pulse_req(3);
        pulse_req(3);
        step(3);
        chk("R5 queued", int'(stat_pend), 2);
        stall_mode = 0;
        step(100);
        chk("R4 R5 writes", wr_k, 24);
        chk("R5 drained", int'(stat_pend), 0);
        chk("R6 reads", cmd_k, 32);
        chk("R7 data order", data_err, 0);

        // R8: completion drops queued requests
        stall_mode = 2;
        start_chan(1'b1, 4, 4);
        pulse_req(3);
        pulse_req(3);
        pulse_req(3);
        step(3);
        chk("R5 queued", int'(stat_pend), 2);
        stall_mode = 0;
        step(30);
        chk("R8 done", int'(stat_done), 1);
        chk("R8 pend cleared", int'(stat_pend), 0);
        chk("R8 writes", wr_k, 4);

        // R11: a long request counts once
        start_chan(1'b1, 1, 10);
        pulse_req(25);
        step(30);
        chk("R11 one block", wr_k, 1);
        chk("R7 data order", data_err, 0);

        finish_run();
    end

endmodule